// File: doc/BRIEF.md
# Periodic countdown timer bank

The block is a bank of independent down-counting timer channels reached through a small word-addressed register port. Software programs a reload value per channel and turns the channel on. The counter then steps down by one every clock. When it has reached zero, the next clock raises the channel's expiry flag and refills the counter from the reload value, so the channel produces a steady stream of timeouts. The flag is sticky until software clears it. It drives the channel's interrupt line when that channel's interrupt enable is set.

A reload value written while a channel is running is held back until the next expiry. Only turning the channel off and on again abandons the period in progress. A module-level hold bit, qualified by an external debug-mode input, stops every counter at once so that a halted processor does not miss its timeouts.

Top module: `pulse_timer_bank`

## Requirements
- R1: After reset every reload, count, control and flag register reads 0, the hold bit reads 0 and all interrupt outputs are 0.
- R2: Register map, with word-aligned addresses only. The module control register is at 0x000, and bit 0 is the hold bit. For channel i the reload value is at 0x100+16*i (read/write, 32 bits), the live count at 0x104+16*i, control at 0x108+16*i (bit 0 run, bit 1 interrupt enable) and the flag at 0x10C+16*i (bit 0). Any other address reads 0 and ignores writes.
- R3: The live count register is read-only, and a write to it leaves the count sequence unchanged.
- R4: A write that sets run while the channel is stopped loads the reload value N into the counter at that clock edge. The counter then falls by one per clock and, on the clock after it reads 0, reloads N and sets the flag, giving a period of N+1 cycles.
- R5: A reload value written while the channel runs leaves the count in progress unchanged. The value in the reload register at the expiry edge is the one loaded.
- R6: Clearing run and then setting it again restarts the period at once from the present reload value. Writing run=1 to a channel that is already running does not restart it.
- R7: While the debug-mode input is 1 and the hold bit is 1, no running counter changes and no flag is set. Either condition on its own does not stop counting.
- R8: Writing 1 to flag bit 0 clears the flag, and writing 0 has no effect. If an expiry and a clearing write fall on the same edge, the flag stays set.
- R9: A channel's interrupt output is 1 exactly when its flag is set and its interrupt enable is 1.
- R10: A reload value of 0 makes a running channel expire on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_mode_i | input | 1 | Debug mode active; qualifies the hold bit |
| bus_wr_i | input | 1 | Register write strobe, one word per cycle |
| bus_addr_i | input | ADDR_W (12) | Byte address of the register |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Read data for bus_addr_i, combinational |
| irq_o | output | NUM_CH (4) | Per-channel interrupt outputs |

## Verification
Properties check on every cycle that a running counter steps down by one, reloads and flags on expiry, restarts on a run edge, holds still while halted, and that a flag only drops on a clearing write. They also check that the hold bit and the per-channel write strobes change only on their own decoded writes. The bench's scenarios are needed to show the behaviour seen at the ports. These cover the address map and unmapped reads, a deferred reload value taking effect only at the next expiry, the exact N+1 period, the clash between an expiry and a clearing write, and the rule that neither halt condition alone stops counting.

// File: rtl/ptb_pkg.sv
// Package: shared definitions for the periodic countdown timer bank.
// Assumes word-aligned 32-bit register accesses; address bits [3:2]
// select the register within a 16-byte channel window.
package ptb_pkg;

    // Register selected inside one channel window (address bits [3:2]).
    typedef enum logic [1:0] {
        SEL_RELOAD = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_FLAG   = 2'd3
    } chan_sel_e;

    // Address bits above this position select the channel region.
    localparam int unsigned REGION_LSB = 8;
    // Value of the region field that maps the channel windows.
    localparam int unsigned CHAN_REGION = 1;
    // Channel windows are 16 bytes apart.
    localparam int unsigned WIN_LSB = 4;

endpackage

// File: rtl/ptb_regif.sv
// Module: ptb_regif
// Decodes the register port into per-channel write strobes, holds the
// module hold bit and returns read data. Assumes one access per cycle,
// word-aligned addresses, and at most 16 channels in the channel region.
module ptb_regif
    import ptb_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic                           wbit0_i,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  ch_reload_i,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  ch_count_i,
    input  logic [NUM_CH-1:0][1:0]         ch_ctrl_i,
    input  logic [NUM_CH-1:0]              ch_flag_i,
    output logic [NUM_CH-1:0]              wr_reload_o,
    output logic [NUM_CH-1:0]              wr_ctrl_o,
    output logic [NUM_CH-1:0]              wr_flag_o,
    output logic                           hold_o,
    output logic [DATA_W-1:0]              rdata_o
);

    localparam int unsigned REGION_W = ADDR_W - REGION_LSB;

    logic [3:0]          win_idx;
    chan_sel_e           sel;
    logic                chan_hit;
    logic                mod_hit;
    logic [NUM_CH-1:0]   hit_ch;

    // Split the address into region, window and register fields.
    assign win_idx  = addr_i[REGION_LSB-1:WIN_LSB];
    assign sel      = chan_sel_e'(addr_i[3:2]);
    assign chan_hit = (addr_i[ADDR_W-1:REGION_LSB] == REGION_W'(CHAN_REGION))
                    && (addr_i[1:0] == 2'b00)
                    && (int'(win_idx) < NUM_CH);
    assign mod_hit  = (addr_i == '0);

    // One set of write strobes per channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_strobe
        assign hit_ch[g]      = chan_hit && (win_idx == 4'(g));
        assign wr_reload_o[g] = wr_en_i && hit_ch[g] && (sel == SEL_RELOAD);
        assign wr_ctrl_o[g]   = wr_en_i && hit_ch[g] && (sel == SEL_CTRL);
        assign wr_flag_o[g]   = wr_en_i && hit_ch[g] && (sel == SEL_FLAG);
    end

    // Module hold bit register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_o <= 1'b0;
        end else if (wr_en_i && mod_hit) begin
            hold_o <= wbit0_i;
        end
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        rdata_o = '0;
        if (mod_hit) begin
            rdata_o[0] = hold_o;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit_ch[i]) begin
                case (sel)
                    SEL_RELOAD: rdata_o = ch_reload_i[i];
                    SEL_COUNT:  rdata_o = ch_count_i[i];
                    SEL_CTRL:   rdata_o = DATA_W'(ch_ctrl_i[i]);
                    default:    rdata_o = DATA_W'(ch_flag_i[i]);
                endcase
            end
        end
    end

    // R7: the hold bit changes only through a write to the module register.
    p_hold_write_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && mod_hit) |=> $stable(hold_o));

    // R2: one access never strikes more than one channel register.
    p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_reload_o, wr_ctrl_o, wr_flag_o}));

endmodule

// File: rtl/ptb_channel.sv
// Module: ptb_channel
// One countdown channel: reload register, run and interrupt-enable bits,
// down-counter with automatic reload, and a sticky expiry flag.
// Assumes the write strobes come from a decoder that asserts at most one
// of them per cycle, and that halt_i is already qualified by debug mode.
module ptb_channel #(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_reload_i,
    input  logic              wr_ctrl_i,
    input  logic              wr_flag_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              halt_i,
    output logic [DATA_W-1:0] reload_o,
    output logic [DATA_W-1:0] count_o,
    output logic [1:0]        ctrl_o,
    output logic              flag_o,
    output logic              irq_o
);

    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             ie_q;
    logic             flag_q;
    logic             start;
    logic             expire;
    logic             clear_req;

    // Run edge caused by a control write while stopped; expiry when a live count sits at zero.
    assign start     = wr_ctrl_i && wdata_i[0] && !run_q;
    assign expire    = run_q && !halt_i && !start && (cnt_q == '0);
    assign clear_req = wr_flag_i && wdata_i[0];

    // Reload value register; taken by the counter only at start or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (wr_reload_i) begin
            reload_q <= wdata_i[CNT_W-1:0];
        end
    end

    // Run and interrupt-enable control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            ie_q  <= 1'b0;
        end else if (wr_ctrl_i) begin
            run_q <= wdata_i[0];
            ie_q  <= wdata_i[1];
        end
    end

    // Down-counter: load on run edge, step while running and not halted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= reload_q;
        end else if (run_q && !halt_i) begin
            cnt_q <= expire ? reload_q : (cnt_q - CNT_W'(1));
        end
    end

    // Sticky expiry flag; a set on the same edge beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (expire) begin
            flag_q <= 1'b1;
        end else if (clear_req) begin
            flag_q <= 1'b0;
        end
    end

    assign reload_o = DATA_W'(reload_q);
    assign count_o  = DATA_W'(cnt_q);
    assign ctrl_o   = {ie_q, run_q};
    assign flag_o   = flag_q;
    assign irq_o    = flag_q && ie_q;

    // R4: a running, unhalted, nonzero count falls by exactly one.
    p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !halt_i && !start && (cnt_q != '0))
        |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R5: expiry refills from the reload register and raises the flag.
    p_reload_on_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> ((cnt_q == $past(reload_q)) && flag_q));

    // R6: a run edge starts a fresh period from the present reload value.
    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (run_q && (cnt_q == $past(reload_q))));

    // R7: a halted running channel keeps its count.
    p_halt_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && halt_i && !start) |=> $stable(cnt_q));

    // R8: a set flag drops only through a clearing write.
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clear_req) |=> flag_q);

endmodule

// File: rtl/pulse_timer_bank.sv
// Module: pulse_timer_bank
// Top of the periodic countdown timer bank: register decoder plus
// NUM_CH countdown channels. Assumes a single-cycle write port and a
// combinational read port; the debug-mode input is synchronous to clk.
module pulse_timer_bank
    import ptb_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_mode_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic [NUM_CH-1:0] irq_o
);

    logic [NUM_CH-1:0][DATA_W-1:0] ch_reload;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_count;
    logic [NUM_CH-1:0][1:0]        ch_ctrl;
    logic [NUM_CH-1:0]             ch_flag;
    logic [NUM_CH-1:0]             wr_reload;
    logic [NUM_CH-1:0]             wr_ctrl;
    logic [NUM_CH-1:0]             wr_flag;
    logic                          hold_bit;
    logic                          halt_all;

    // Counting stops only when both the hold bit and debug mode are active.
    assign halt_all = hold_bit && dbg_mode_i;

    ptb_regif #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regif (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (bus_wr_i),
        .addr_i      (bus_addr_i),
        .wbit0_i     (bus_wdata_i[0]),
        .ch_reload_i (ch_reload),
        .ch_count_i  (ch_count),
        .ch_ctrl_i   (ch_ctrl),
        .ch_flag_i   (ch_flag),
        .wr_reload_o (wr_reload),
        .wr_ctrl_o   (wr_ctrl),
        .wr_flag_o   (wr_flag),
        .hold_o      (hold_bit),
        .rdata_o     (bus_rdata_o)
    );

    // One countdown channel per index.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        ptb_channel #(
            .CNT_W  (CNT_W),
            .DATA_W (DATA_W)
        ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_reload_i (wr_reload[g]),
            .wr_ctrl_i   (wr_ctrl[g]),
            .wr_flag_i   (wr_flag[g]),
            .wdata_i     (bus_wdata_i),
            .halt_i      (halt_all),
            .reload_o    (ch_reload[g]),
            .count_o     (ch_count[g]),
            .ctrl_o      (ch_ctrl[g]),
            .flag_o      (ch_flag[g]),
            .irq_o       (irq_o[g])
        );
    end

endmodule

// File: tb/pulse_timer_bank_test.sv
// Bench: drives the register port and debug input, keeps a behavioural
// model of every channel, and compares counts, flags and interrupts after
// each clock as well as in directed scenarios.
module pulse_timer_bank_test;

    localparam int CLK_PERIOD = 40;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Behavioural model state.
    logic [31:0] m_ld [NCH];
    logic [31:0] m_cnt [NCH];
    bit          m_en [NCH];
    bit          m_ie [NCH];
    bit          m_flag [NCH];
    bit          m_frz;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_timer_bank uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .dbg_mode_i  (dbg),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq)
    );

    function automatic logic [11:0] a_ld(int i); return 12'(256 + 16*i); endfunction
    function automatic logic [11:0] a_cv(int i); return 12'(260 + 16*i); endfunction
    function automatic logic [11:0] a_ct(int i); return 12'(264 + 16*i); endfunction
    function automatic logic [11:0] a_fl(int i); return 12'(268 + 16*i); endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Model update for one clock edge with the write presented on it.
    task automatic model_step(input bit we, input logic [11:0] a, input logic [31:0] d);
        bit halt;
        halt = dbg && m_frz;
        for (int i = 0; i < NCH; i++) begin
            bit start;
            bit fire;
            start = we && (a == a_ct(i)) && d[0] && !m_en[i];
            fire = 1'b0;
            if (start) m_cnt[i] = m_ld[i];
            else if (m_en[i] && !halt) begin
                if (m_cnt[i] == 0) begin
                    m_cnt[i] = m_ld[i];
                    fire = 1'b1;
                end else begin
                    m_cnt[i] = m_cnt[i] - 1;
                end
            end
            if (fire) m_flag[i] = 1'b1;
            else if (we && (a == a_fl(i)) && d[0]) m_flag[i] = 1'b0;
        end
        if (we) begin
            for (int i = 0; i < NCH; i++) begin
                if (a == a_ld(i)) m_ld[i] = d;
                if (a == a_ct(i)) begin
                    m_en[i] = d[0];
                    m_ie[i] = d[1];
                end
            end
            if (a == 12'h000) m_frz = d[0];
        end
    endtask

    // Per-cycle comparison of every channel against the model.
    task automatic compare_all();
        logic [31:0] v;
        logic [3:0]  exp_irq;
        for (int i = 0; i < NCH; i++) begin
            rd(a_cv(i), v);
            if (m_en[i]) chk("R4 model count", v, m_cnt[i]);
            rd(a_fl(i), v);
            chk("R8 model flag", v, {31'b0, m_flag[i]});
            exp_irq[i] = m_flag[i] && m_ie[i];
        end
        chk("R9 model irq", {28'b0, irq}, {28'b0, exp_irq});
    endtask

    task automatic tick(input bit we, input logic [11:0] a, input logic [31:0] d);
        bus_wr = we;
        bus_addr = a;
        bus_wdata = d;
        @(posedge clk);
        model_step(we, a, d);
        @(negedge clk);
        bus_wr = 1'b0;
        compare_all();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < NCH; i++) begin
            m_ld[i] = '0; m_cnt[i] = '0; m_en[i] = 0; m_ie[i] = 0; m_flag[i] = 0;
        end
        m_frz = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < NCH; i++) begin
            rd(a_ld(i), v); chk("R1 reload", v, 0);
            rd(a_cv(i), v); chk("R1 count", v, 0);
            rd(a_ct(i), v); chk("R1 ctrl", v, 0);
            rd(a_fl(i), v); chk("R1 flag", v, 0);
        end
        rd(12'h000, v); chk("R1 hold bit", v, 0);
        chk("R1 irq", {28'b0, irq}, 0);
        @(negedge clk);

        // R2: map and unmapped reads
        tick(1, a_ld(0), 32'h0000_00A5);
        tick(1, a_ld(3), 32'hFFFF_0001);
        rd(a_ld(0), v); chk("R2 reload ch0", v, 32'h0000_00A5);
        rd(a_ld(3), v); chk("R2 reload ch3", v, 32'hFFFF_0001);
        tick(1, 12'h140, 32'h1234_5678);
        rd(12'h0F0, v); chk("R2 unmapped 0x0F0", v, 0);
        rd(12'h140, v); chk("R2 unmapped 0x140", v, 0);

        // R4: period N+1 with N=3 on channel 1, interrupt enabled
        tick(1, a_ld(1), 32'd3);
        tick(1, a_ct(1), 32'd3);
        rd(a_cv(1), v); chk("R4 load on run edge", v, 3);
        repeat (3) tick(0, 12'h000, 0);
        rd(a_fl(1), v); chk("R4 no flag before expiry", v, 0);
        rd(a_cv(1), v); chk("R4 count at zero", v, 0);
        tick(0, 12'h000, 0);
        rd(a_fl(1), v); chk("R4 flag on expiry", v, 1);
        rd(a_cv(1), v); chk("R5 reload after expiry", v, 3);
        chk("R9 irq with flag and enable", {31'b0, irq[1]}, 1);
        tick(1, a_fl(1), 32'd1);
        rd(a_fl(1), v); chk("R8 write-1 clears", v, 0);
        repeat (3) tick(0, 12'h000, 0);
        rd(a_fl(1), v); chk("R4 second expiry", v, 1);
        tick(1, a_fl(1), 32'd0);
        rd(a_fl(1), v); chk("R8 write-0 no effect", v, 1);
        tick(1, a_ct(1), 32'd1);
        chk("R9 irq masked", {31'b0, irq[1]}, 0);
        rd(a_fl(1), v); chk("R9 flag kept while masked", v, 1);
        tick(1, a_ct(1), 32'd0);

        // R5: deferred reload value on channel 2
        tick(1, a_ld(2), 32'd10);
        tick(1, a_ct(2), 32'd1);
        repeat (2) tick(0, 12'h000, 0);
        tick(1, a_ld(2), 32'd2);
        rd(a_cv(2), v); chk("R5 count undisturbed", v, 7);
        repeat (8) tick(0, 12'h000, 0);
        rd(a_cv(2), v); chk("R5 new reload at expiry", v, 2);
        rd(a_fl(2), v); chk("R5 flag at expiry", v, 1);

        // R6: stop, new value, start
        tick(1, a_ct(2), 32'd0);
        tick(1, a_ld(2), 32'd5);
        tick(1, a_ct(2), 32'd1);
        rd(a_cv(2), v); chk("R6 restart from present reload", v, 5);
        tick(1, a_ct(2), 32'd1);
        rd(a_cv(2), v); chk("R6 run rewrite no restart", v, 4);

        // R3: count register write ignored
        tick(1, a_cv(2), 32'h0000_DEAD);
        rd(a_cv(2), v); chk("R3 count read-only", v, 3);

        // R7: halt qualification
        tick(1, 12'h000, 32'd1);
        rd(12'h000, v); chk("R2 hold bit readback", v, 1);
        rd(a_cv(2), v); chk("R7 hold bit alone counts", v, 2);
        dbg = 1'b1;
        repeat (3) tick(0, 12'h000, 0);
        rd(a_cv(2), v); chk("R7 halted count", v, 2);
        tick(1, 12'h000, 32'd0);
        rd(a_cv(2), v); chk("R7 halted on release edge", v, 2);
        tick(0, 12'h000, 0);
        rd(a_cv(2), v); chk("R7 debug alone counts", v, 1);
        dbg = 1'b0;

        // R10: reload value 0 expires every cycle, and set beats clear
        tick(1, a_ld(3), 32'd0);
        tick(1, a_ct(3), 32'd1);
        tick(0, 12'h000, 0);
        rd(a_fl(3), v); chk("R10 flag each cycle", v, 1);
        rd(a_cv(3), v); chk("R10 count stays zero", v, 0);
        tick(1, a_fl(3), 32'd1);
        rd(a_fl(3), v); chk("R8 set wins over clear", v, 1);
        tick(1, a_ct(3), 32'd0);
        repeat (4) tick(0, 12'h000, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule